// File: doc/BRIEF.md
# UART Receive Deserializer with Error Detection

This block turns an asynchronous serial line into characters. A free-running enable pulse at sixteen times the baud rate drives the block. It watches the line for a high-to-low transition and checks the line again halfway through the start bit. If the line has already returned high, the transition is treated as noise and dropped. Otherwise it samples each later bit at its centre and assembles a character of five to eight data bits, least significant bit first. It then checks an optional parity bit and the first stop bit.

Each finished character goes into a sixteen-entry queue together with its own parity, framing and break flags, so every error stays attached to the character it belongs to. The head of the queue is always visible on the read outputs. The current fill count, a data-available level and a sticky overrun flag are reported alongside. An input selector lets the receiver listen either to the external pin or to an internal transmit line, for loopback testing.

A held-low line (break) is told apart from an ordinary framing error. It produces exactly one all-zero entry with its own flag. The receiver then stays quiet until the line goes high again.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, fill_level is 0, data_avail is 0 and overrun is 0.
- R2: data_len selects the number of data bits, with 0, 1, 2 and 3 meaning 5, 6, 7 and 8. Bits arrive least significant first and are stored right-aligned in rd_data, with the unused upper bits set to zero.
- R3: parity_mode selects the parity check: 0 none, 1 even, 2 odd, 3 always one, 4 always zero. rd_perr is 1 when the sampled parity bit differs from the expected value, and it is always 0 with no parity.
- R4: A low pulse on the line that is over before the middle of the start bit, sampled at the eighth 16x tick, produces no character.
- R5: A character whose first stop bit samples low, and which is not a break, is stored with rd_ferr=1. Only the first stop bit is checked. After any low stop bit the receiver waits for the line to be high before it looks for a new start.
- R6: When all data bits, the parity bit (if enabled) and the stop bit sample low, exactly one entry is stored with rd_data=0, rd_brk=1, rd_ferr=0 and rd_perr=0. No further entry is stored until the line has been high again.
- R7: The queue holds 16 entries in arrival order and its head is shown on rd_data, rd_perr, rd_ferr and rd_brk. rd_en removes the head. fill_level gives the entry count, and data_avail is 1 exactly when that count is non-zero. A read of an empty queue has no effect.
- R8: A character that completes while the queue holds 16 entries is discarded and the stored entries are kept. overrun becomes 1 and stays 1 until ovr_clr is pulsed.
- R9: With loop_sel=1 the receiver takes its input from loop_txd and ignores rxd. With loop_sel=0 it takes rxd.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the baud rate |
| loop_sel | input | 1 | 1 selects loop_txd as the receive input |
| rxd | input | 1 | External serial input |
| loop_txd | input | 1 | Internal transmit line used for loopback |
| data_len | input | 2 | Data bits minus five |
| parity_mode | input | 3 | Parity selection (see R3) |
| rd_en | input | 1 | Removes the head entry |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break flag |
| fill_level | output | 5 | Number of stored entries |
| data_avail | output | 1 | At least one entry is stored |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Random frames mix every data length and parity mode with correct parity, inverted parity and low stop bits. Comparing them against a bench model separates parity-polarity errors, length and bit-order errors, and misclassification between framing errors and breaks. Directed cases cover the rest:
- A short low glitch checks that false starts are rejected.
- A line held low for many bit times checks that a break yields exactly one entry.
- A burst of seventeen frames with no reads checks the full-queue discard and the sticky overrun flag.
- A frame sent on the loopback line, while the external pin is held low, shows which input is actually used.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_EVEN = 3'd1,
    PAR_ODD  = 3'd2,
    PAR_ONE  = 3'd3,
    PAR_ZERO = 3'd4
  } par_mode_e;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_word_t;

endpackage

// File: rtl/rx_line_sampler.sv
module rx_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_sel,
  input  logic rxd,
  input  logic loop_txd,
  output logic rx_s
);

  logic              rx_mux;
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    rx_mux = loop_sel ? loop_txd : rxd;
    sync_d = {sync_q[STAGES-2:0], rx_mux};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign rx_s = sync_q[STAGES-1];

endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx,
  input  logic [1:0] data_len,
  input  par_mode_e pmode,
  output logic      push,
  output rx_word_t  push_word
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID_LAST = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } st_e;

  st_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]   bidx_q, bidx_d;
  logic [7:0]   sh_q, sh_d;
  logic         par_q, par_d;
  logic         push_d;
  rx_word_t     word_d;
  logic         exp_par;
  logic         is_brk;
  logic [2:0]   last_idx;

  always_comb begin
    last_idx = {1'b0, data_len} + 3'd4;
    unique case (pmode)
      PAR_EVEN: exp_par = ^sh_q;
      PAR_ODD:  exp_par = ~^sh_q;
      PAR_ONE:  exp_par = 1'b1;
      default:  exp_par = 1'b0;
    endcase
    is_brk = !rx && (sh_q == 8'd0) && ((pmode == PAR_NONE) || !par_q);
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    push_d = 1'b0;
    word_d = '0;
    if (tick) begin
      unique case (st_q)
        S_IDLE: if (!rx) begin
          st_d  = S_START;
          cnt_d = '0;
        end
        S_START: begin
          if (cnt_q == MID_LAST) begin
            cnt_d  = '0;
            bidx_d = '0;
            sh_d   = '0;
            par_d  = 1'b0;
            st_d   = rx ? S_IDLE : S_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt_q == BIT_LAST) begin
            cnt_d        = '0;
            sh_d[bidx_q] = rx;
            if (bidx_q == last_idx) st_d = (pmode == PAR_NONE) ? S_STOP : S_PAR;
            else                    bidx_d = bidx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_PAR: begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            par_d = rx;
            st_d  = S_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt_q == BIT_LAST) begin
            push_d = 1'b1;
            if (is_brk) begin
              word_d.brk = 1'b1;
            end else begin
              word_d.data = sh_q;
              word_d.ferr = !rx;
              word_d.perr = (pmode != PAR_NONE) && (par_q != exp_par);
            end
            st_d = rx ? S_IDLE : S_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_HOLD:  if (rx) st_d = S_IDLE;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      bidx_q    <= '0;
      sh_q      <= '0;
      par_q     <= 1'b0;
      push      <= 1'b0;
      push_word <= '0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      bidx_q    <= bidx_d;
      sh_q      <= sh_d;
      par_q     <= par_d;
      push      <= push_d;
      push_word <= word_d;
    end
  end

endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  rx_word_t                   push_word,
  input  logic                       pop,
  input  logic                       ovr_clr,
  output rx_word_t                   head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovr
);

  localparam int AW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  rx_word_t        mem [DEPTH];
  logic [AW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CNTW-1:0] cnt_d;
  logic            ovr_d;
  logic            do_wr, do_rd, full;

  always_comb begin
    full  = (count == FULL_CNT);
    do_wr = push && !full;
    do_rd = pop && (count != '0);
    wp_d  = do_wr ? wp_q + 1'b1 : wp_q;
    rp_d  = do_rd ? rp_q + 1'b1 : rp_q;
    cnt_d = count;
    if (do_wr && !do_rd) cnt_d = count + 1'b1;
    if (!do_wr && do_rd) cnt_d = count - 1'b1;
    ovr_d = ovr;
    if (ovr_clr)      ovr_d = 1'b0;
    if (push && full) ovr_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      count <= cnt_d;
      ovr   <= ovr_d;
    end
  end

  assign head = mem[rp_q];

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       loop_sel,
  input  logic       rxd,
  input  logic       loop_txd,
  input  logic [1:0] data_len,
  input  logic [2:0] parity_mode,
  input  logic       rd_en,
  input  logic       ovr_clr,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic [4:0] fill_level,
  output logic       data_avail,
  output logic       overrun
);

  localparam int CNTW = $clog2(DEPTH + 1);

  logic            rx_s;
  logic            rx_push;
  rx_word_t        rx_word;
  rx_word_t        head;
  logic [CNTW-1:0] cnt;

  rx_line_sampler #(.STAGES(SYNC_STAGES)) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .loop_sel (loop_sel),
    .rxd      (rxd),
    .loop_txd (loop_txd),
    .rx_s     (rx_s)
  );

  rx_deframer #(.OVS(OVS)) u_defr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .rx        (rx_s),
    .data_len  (data_len),
    .pmode     (par_mode_e'(parity_mode)),
    .push      (rx_push),
    .push_word (rx_word)
  );

  rx_word_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_word (rx_word),
    .pop       (rd_en),
    .ovr_clr   (ovr_clr),
    .head      (head),
    .count     (cnt),
    .ovr       (overrun)
  );

  assign rd_data    = head.data;
  assign rd_perr    = head.perr;
  assign rd_ferr    = head.ferr;
  assign rd_brk     = head.brk;
  assign fill_level = 5'(cnt);
  assign data_avail = (cnt != '0);

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_push,
  input logic       rd_en,
  input logic       ovr_clr,
  input logic [4:0] fill_level,
  input logic       data_avail,
  input logic       overrun,
  input logic [7:0] rd_data,
  input logic       rd_ferr,
  input logic       rd_perr,
  input logic       rd_brk
);

  localparam logic [4:0] FULL = 5'(DEPTH);

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= FULL);

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == 5'd0 && !rx_push) |=> fill_level == 5'd0);

  assert_pop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fill_level != 5'd0 && !rx_push) |=> fill_level == $past(fill_level) - 5'd1);

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && fill_level == FULL) |=> overrun);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  assert_full_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && fill_level == FULL && !rd_en) |=> fill_level == FULL);

  assert_brk_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_avail && rd_brk) |-> (rd_data == 8'd0 && !rd_ferr && !rd_perr));

endmodule

bind uart_rx_core uart_rx_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_push    (rx_push),
  .rd_en      (rd_en),
  .ovr_clr    (ovr_clr),
  .fill_level (fill_level),
  .data_avail (data_avail),
  .overrun    (overrun),
  .rd_data    (rd_data),
  .rd_ferr    (rd_ferr),
  .rd_perr    (rd_perr),
  .rd_brk     (rd_brk)
);

// File: tb/uart_rx_core_test.sv
`timescale 1ns/1ps
module uart_rx_core_test;

  localparam int BITC = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic loop_sel = 1'b0;
  logic rxd = 1'b1;
  logic loop_txd = 1'b1;
  logic [1:0] data_len = 2'd3;
  logic [2:0] parity_mode = 3'd0;
  logic rd_en = 1'b0;
  logic ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk;
  logic [4:0] fill_level;
  logic data_avail, overrun;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic use_loop = 1'b0;
  logic [10:0] expq [32];

  uart_rx_core uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .loop_sel(loop_sel),
    .rxd(rxd), .loop_txd(loop_txd), .data_len(data_len),
    .parity_mode(parity_mode), .rd_en(rd_en), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rd_brk(rd_brk), .fill_level(fill_level), .data_avail(data_avail),
    .overrun(overrun)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dmask(input logic [7:0] d, input int nb);
    return d & 8'((1 << nb) - 1);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input int nb, input int pm);
    logic [7:0] m;
    m = dmask(d, nb);
    case (pm)
      1: return ^m;
      2: return ~^m;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [10:0] exp_word(input logic [7:0] d, input int nb, input int pm,
                                           input logic flip, input logic stopv);
    logic [7:0] m;
    logic pb;
    m  = dmask(d, nb);
    pb = par_bit(d, nb, pm) ^ flip;
    if (m == 8'd0 && (pm == 0 || !pb) && !stopv) return 11'h400;
    return {1'b0, !stopv, (pm != 0) && flip, m};
  endfunction

  task automatic drive_bit(input logic v);
    if (use_loop) loop_txd = v;
    else          rxd = v;
    wait_clk(BITC);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input int pm,
                            input logic flip, input logic stopv);
    data_len    = 2'(nb - 5);
    parity_mode = 3'(pm);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (pm != 0) drive_bit(par_bit(d, nb, pm) ^ flip);
    drive_bit(stopv);
    drive_bit(1'b1);
  endtask

  task automatic pop_check(input string tag, input logic [10:0] exp);
    chk(tag, {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, exp});
    rd_en = 1'b1;
    wait_clk(1);
    rd_en = 1'b0;
    wait_clk(1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [7:0] d;
    int nb, pm;
    logic flip, stopv;
    void'($urandom(32'd20250611));
    wait_clk(5);
    chk("R1 fill after reset", 32'(fill_level), 32'd0);
    chk("R1 avail after reset", 32'(data_avail), 32'd0);
    chk("R1 overrun after reset", 32'(overrun), 32'd0);
    rst_n = 1'b1;
    wait_clk(BITC);

    // R2 R3 R5: random formats, parity flips and low stop bits
    for (int k = 0; k < 24; k++) begin
      d     = 8'($urandom);
      nb    = 5 + int'($urandom % 4);
      pm    = int'($urandom % 5);
      flip  = ($urandom % 4) == 0;
      stopv = ($urandom % 5) != 0;
      if (k == 0) begin d = 8'h00; pm = 4; flip = 1'b0; stopv = 1'b0; end
      if (k == 1) begin d = 8'h80; nb = 8; pm = 1; flip = 1'b1; stopv = 1'b1; end
      send_frame(d, nb, pm, flip, stopv);
      chk("R7 fill one frame", 32'(fill_level), 32'd1);
      chk("R7 avail one frame", 32'(data_avail), 32'd1);
      pop_check("R2 R3 R5 R6 frame entry", exp_word(d, nb, pm, flip, stopv));
    end

    // R4: short glitch
    rxd = 1'b0; wait_clk(20); rxd = 1'b1;
    wait_clk(3 * BITC);
    chk("R4 glitch gives no entry", 32'(fill_level), 32'd0);

    // R6: held-low break
    data_len = 2'd3; parity_mode = 3'd1;
    rxd = 1'b0; wait_clk(20 * BITC); rxd = 1'b1;
    wait_clk(3 * BITC);
    chk("R6 single break entry", 32'(fill_level), 32'd1);
    pop_check("R6 break word", 11'h400);
    chk("R6 empty after break", 32'(fill_level), 32'd0);

    // R9: loopback while external pin held low
    loop_sel = 1'b1; use_loop = 1'b1; rxd = 1'b0;
    wait_clk(2 * BITC);
    send_frame(8'hA5, 8, 2, 1'b0, 1'b1);
    chk("R9 loopback fill", 32'(fill_level), 32'd1);
    pop_check("R9 loopback word", exp_word(8'hA5, 8, 2, 1'b0, 1'b1));
    rxd = 1'b1; loop_sel = 1'b0; use_loop = 1'b0;
    wait_clk(2 * BITC);

    // R8: seventeen frames with no reads
    for (int k = 0; k < 17; k++) begin
      d = 8'($urandom) | 8'h01;
      expq[k] = exp_word(d, 8, 0, 1'b0, 1'b1);
      send_frame(d, 8, 0, 1'b0, 1'b1);
    end
    chk("R8 fill held at full", 32'(fill_level), 32'd16);
    chk("R8 overrun set", 32'(overrun), 32'd1);
    for (int k = 0; k < 16; k++) pop_check("R8 R7 kept entry order", expq[k]);
    chk("R8 extra frame discarded", 32'(fill_level), 32'd0);
    chk("R8 overrun still sticky", 32'(overrun), 32'd1);
    ovr_clr = 1'b1; wait_clk(1); ovr_clr = 1'b0; wait_clk(1);
    chk("R8 overrun cleared", 32'(overrun), 32'd0);

    // R7: read of empty queue
    rd_en = 1'b1; wait_clk(1); rd_en = 1'b0; wait_clk(1);
    chk("R7 empty read fill", 32'(fill_level), 32'd0);
    chk("R7 empty read avail", 32'(data_avail), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule